// File: doc/BRIEF.md
# Subtractive GCD Engine with Serial Operand Loading

This block computes the greatest common divisor of two unsigned integers by repeated subtraction. Both operands arrive one after the other on a single shared data input. The request input is only a start strobe that says new data is present. The acknowledge output is only a done strobe. Neither line forms a full four-phase handshake.

The environment raises request with the first operand on the data input. The block captures it and then raises acknowledge. That acknowledge gives the environment permission to put the second operand on the same input. Once the block captures the second operand, it drops acknowledge and computes. In each compute step it subtracts the smaller working value from the larger one, until the two values are equal or one of them is zero. The block then registers the result, pulses acknowledge for one cycle and goes back to waiting. While a computation runs, the block ignores request and the data input.

The controller has seven states. Each state has a fixed 3-bit binary code, and the block drives that code on an output port so that logic outside it can observe the sequence. The registers are kept in their own storage module, apart from the next-state and datapath logic.

Top module: `sub_gcd`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the state with code 000, and after that edge `ack_o` is low and `result_o` is 0. This includes a reset raised in the middle of a computation.
- R2: The state codes are fixed. 000 waits for the first operand, 001 raises acknowledge, 010 waits for the second operand, 011 drops acknowledge, 100 compares, 101 subtracts and 110 writes the result. A transaction visits them in this order, with 100 and 101 alternating until the compare ends.
- R3: In state 000 with `req_i` low, the block stays in 000 and `result_o` is unchanged. With `req_i` high, the block captures `data_i` as the first operand and moves to 001. One edge later it is in 010 with `ack_o` high. `ack_o` stays high while the block waits in 010.
- R4: In state 010 with `req_i` high, the block captures `data_i` as the second operand and moves to 011 with `ack_o` still high. On the next edge it moves to 100 with `ack_o` low.
- R5: For two non-zero operands, `result_o` becomes their greatest common divisor. The block computes it by subtraction steps, each of which changes at most one of the two working values. In the cycle after state 110, the state is 000, `ack_o` is high for exactly that one cycle and `result_o` holds the result.
- R6: If one operand is zero, the result is the other operand. If both operands are zero, the result is 0. The computation still ends through state 110.
- R7: In states 100, 101 and 110, `ack_o` is low. Activity on `req_i` and `data_i` there has no effect on the result or on the state sequence.
- R8: State code 111 never appears on `state_o`. If the controller ever held it, it would return to 000.
- R9: `result_o` changes only on the edge that leaves state 110. It holds its value through the following transaction until that transaction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Start strobe: an operand is present on data_i |
| data_i | input | W | Shared operand input, first operand then second |
| ack_o | output | 1 | Acknowledge: first operand taken, or result ready |
| result_o | output | W | Registered GCD result |
| state_o | output | 3 | Binary code of the controller state |

## Verification
The bench builds the engine at 5 bits and runs every ordered operand pair, from (0,0) to (31,31). The results are compared with a modulo-based Euclid computation in the bench. Pairs that include zero test the early-exit paths. Equal pairs test the immediate exit from the compare state. Pairs such as (31,1) produce the longest subtraction chains, and swapped pairs show whether the block picks the correct operand to reduce. Throughout each computation the bench toggles request and writes changing data. It also checks the state codes and acknowledge levels of the load phase, and it applies a reset in the middle of a computation.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // Controller state codes; they appear on the state_o port.
  typedef enum logic [2:0] {
    ST_LOAD_A   = 3'b000,
    ST_ACK_A    = 3'b001,
    ST_LOAD_B   = 3'b010,
    ST_DROP_ACK = 3'b011,
    ST_CMP      = 3'b100,
    ST_STEP     = 3'b101,
    ST_DONE     = 3'b110
  } gcd_state_t;

  // Datapath operation chosen by the controller for this cycle.
  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_LD_A   = 3'd1,
    OP_LD_B   = 3'd2,
    OP_SUB    = 3'd3,
    OP_COPY_B = 3'd4
  } gcd_op_t;

  // Command for the acknowledge flop.
  typedef enum logic [1:0] {
    ACK_KEEP = 2'd0,
    ACK_SET  = 2'd1,
    ACK_CLR  = 2'd2
  } ack_cmd_t;

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  gcd_state_t state_q,
  input  logic       req_i,
  input  logic       eq_i,
  input  logic       a_zero_i,
  input  logic       b_zero_i,
  output gcd_state_t state_d,
  output gcd_op_t    op_o,
  output ack_cmd_t   ack_cmd_o,
  output logic       res_we_o
);

  always_comb begin
    state_d   = state_q;
    op_o      = OP_HOLD;
    ack_cmd_o = ACK_KEEP;
    res_we_o  = 1'b0;
    case (state_q)
      ST_LOAD_A: begin
        // Clears the one-cycle done pulse on the way through.
        ack_cmd_o = ACK_CLR;
        if (req_i) begin
          op_o    = OP_LD_A;
          state_d = ST_ACK_A;
        end
      end
      ST_ACK_A: begin
        ack_cmd_o = ACK_SET;
        state_d   = ST_LOAD_B;
      end
      ST_LOAD_B: begin
        if (req_i) begin
          op_o    = OP_LD_B;
          state_d = ST_DROP_ACK;
        end
      end
      ST_DROP_ACK: begin
        ack_cmd_o = ACK_CLR;
        state_d   = ST_CMP;
      end
      ST_CMP: begin
        if (a_zero_i) begin
          // The result is B (0 when both are zero); it is moved into A.
          op_o    = OP_COPY_B;
          state_d = ST_DONE;
        end else if (b_zero_i || eq_i) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        op_o    = OP_SUB;
        state_d = ST_CMP;
      end
      ST_DONE: begin
        res_we_o  = 1'b1;
        ack_cmd_o = ACK_SET;
        state_d   = ST_LOAD_A;
      end
      default: begin
        // Code 111 is unused: return to the idle state.
        ack_cmd_o = ACK_CLR;
        state_d   = ST_LOAD_A;
      end
    endcase
  end

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  gcd_op_t      op_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] a_q,
  input  logic [W-1:0] b_q,
  output logic [W-1:0] a_d,
  output logic [W-1:0] b_d,
  output logic         eq_o,
  output logic         a_zero_o,
  output logic         b_zero_o
);

  localparam logic [W-1:0] ZERO = '0;

  logic         a_gt_b;
  logic [W-1:0] a_minus_b;
  logic [W-1:0] b_minus_a;

  assign a_gt_b    = a_q > b_q;
  assign a_minus_b = a_q - b_q;
  assign b_minus_a = b_q - a_q;
  assign eq_o      = a_q == b_q;
  assign a_zero_o  = a_q == ZERO;
  assign b_zero_o  = b_q == ZERO;

  // Each operation writes at most one of the two working values.
  always_comb begin
    a_d = a_q;
    b_d = b_q;
    case (op_i)
      OP_LD_A:   a_d = data_i;
      OP_LD_B:   b_d = data_i;
      OP_COPY_B: a_d = b_q;
      OP_SUB: begin
        if (a_gt_b) a_d = a_minus_b;
        else        b_d = b_minus_a;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gcd_regs.sv
module gcd_regs
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  gcd_state_t   state_d,
  input  logic [W-1:0] a_d,
  input  logic [W-1:0] b_d,
  input  ack_cmd_t     ack_cmd,
  input  logic         res_we,
  output gcd_state_t   state_q,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         ack_q,
  output logic [W-1:0] res_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOAD_A;
      a_q     <= '0;
      b_q     <= '0;
      ack_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      a_q     <= a_d;
      b_q     <= b_d;
      case (ack_cmd)
        ACK_SET: ack_q <= 1'b1;
        ACK_CLR: ack_q <= 1'b0;
        default: ack_q <= ack_q;
      endcase
      if (res_we) res_q <= a_q;
    end
  end

endmodule

// File: rtl/sub_gcd.sv
module sub_gcd
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  output logic         ack_o,
  output logic [W-1:0] result_o,
  output logic [2:0]   state_o
);

  gcd_state_t   state_q, state_d;
  gcd_op_t      op;
  ack_cmd_t     ack_cmd;
  logic         res_we;
  logic [W-1:0] a_q, b_q, a_d, b_d;
  logic         eq, a_zero, b_zero;

  gcd_ctrl u_ctrl (
    .state_q  (state_q),
    .req_i    (req_i),
    .eq_i     (eq),
    .a_zero_i (a_zero),
    .b_zero_i (b_zero),
    .state_d  (state_d),
    .op_o     (op),
    .ack_cmd_o(ack_cmd),
    .res_we_o (res_we)
  );

  gcd_datapath #(.W(W)) u_dp (
    .op_i    (op),
    .data_i  (data_i),
    .a_q     (a_q),
    .b_q     (b_q),
    .a_d     (a_d),
    .b_d     (b_d),
    .eq_o    (eq),
    .a_zero_o(a_zero),
    .b_zero_o(b_zero)
  );

  gcd_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .state_d(state_d),
    .a_d    (a_d),
    .b_d    (b_d),
    .ack_cmd(ack_cmd),
    .res_we (res_we),
    .state_q(state_q),
    .a_q    (a_q),
    .b_q    (b_q),
    .ack_q  (ack_o),
    .res_q  (result_o)
  );

  assign state_o = state_q;

endmodule

// File: rtl/sub_gcd_chk.sv
module sub_gcd_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         req_i,
  input logic         ack_o,
  input logic [W-1:0] result_o,
  input logic [2:0]   state_o,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_o == 3'b000 && !ack_o && result_o == '0));

  // R8
  no_unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    state_o != 3'b111);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b000 && !req_i) |=> (state_o == 3'b000 && !ack_o));

  // R3
  ack_after_a_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b001) |=> (state_o == 3'b010 && ack_o));

  // R4
  drop_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b011) |=> (state_o == 3'b100 && !ack_o));

  // R5
  one_operand_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(a_q) || $stable(b_q)));

  // R2
  step_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b101) |=> (state_o == 3'b100));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b110) |=> (state_o == 3'b000 && ack_o && result_o == $past(a_q)));

  // R7
  compute_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    state_o[2] |-> !ack_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o != 3'b110) |=> $stable(result_o));

endmodule

bind sub_gcd sub_gcd_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .result_o(result_o),
  .state_o (state_o),
  .a_q     (a_q),
  .b_q     (b_q)
);

// File: tb/sub_gcd_bench.sv
module sub_gcd_bench;

  localparam int W     = 5;
  localparam int SPAN  = 1 << W;
  localparam int LIMIT = 4 * SPAN + 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         ack_o;
  logic [W-1:0] result_o;
  logic [2:0]   state_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] prev_res = '0;

  sub_gcd #(.W(W)) u_sub_gcd (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .data_i  (data_i),
    .ack_o   (ack_o),
    .result_o(result_o),
    .state_o (state_o)
  );

  always #5 clk = ~clk;

  function automatic int ref_gcd(input int x, input int y);
    int p = x;
    int q = y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full transaction; req and data toggle during the compute phase (R7).
  task automatic run_pair(input int a, input int b);
    int n;
    int exp;
    @(negedge clk);
    data_i = a[W-1:0];
    req_i  = 1'b1;
    @(negedge clk);
    check(state_o == 3'b001 && !ack_o, "R2 first capture state", state_o, 1);
    @(negedge clk);
    check(state_o == 3'b010 && ack_o, "R3 ack after first operand", {state_o, ack_o}, 5);
    check(result_o == prev_res, "R9 result held", result_o, prev_res);
    data_i = b[W-1:0];
    @(negedge clk);
    check(state_o == 3'b011 && ack_o, "R4 second capture", {state_o, ack_o}, 7);
    data_i = ~b[W-1:0];
    @(negedge clk);
    check(state_o == 3'b100 && !ack_o, "R4 ack dropped", {state_o, ack_o}, 8);
    n = 0;
    while (!ack_o && n < LIMIT) begin
      if (state_o == 3'b111) check(1'b0, "R8 unused code", state_o, 0);
      req_i  = n[0];
      data_i = data_i + 5'd3;
      @(negedge clk);
      n++;
    end
    req_i = 1'b0;
    exp = ref_gcd(a, b);
    check(ack_o && state_o == 3'b000, "R5 done pulse", {state_o, ack_o}, 1);
    if (a == 0 || b == 0)
      check(result_o == exp[W-1:0], "R6 zero operand result", result_o, exp);
    else
      check(result_o == exp[W-1:0], "R5 gcd result", result_o, exp);
    prev_res = result_o;
    @(negedge clk);
    check(!ack_o && state_o == 3'b000, "R5 ack one cycle", ack_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(state_o == 3'b000, "R1 reset state", state_o, 0);
    check(!ack_o, "R1 reset ack", ack_o, 0);
    check(result_o == '0, "R1 reset result", result_o, 0);

    // R3 idle: no request, nothing moves
    repeat (4) @(negedge clk);
    check(state_o == 3'b000 && result_o == '0, "R3 idle hold", state_o, 0);

    for (int a = 0; a < SPAN; a++)
      for (int b = 0; b < SPAN; b++)
        run_pair(a, b);

    // R9 result stays through idle cycles
    repeat (3) @(negedge clk);
    check(result_o == prev_res, "R9 result held idle", result_o, prev_res);

    // R1 reset in the middle of a long computation
    @(negedge clk);
    data_i = 5'd31; req_i = 1'b1;
    repeat (2) @(negedge clk);
    data_i = 5'd1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(state_o == 3'b000 && !ack_o, "R1 mid-run reset", {state_o, ack_o}, 0);
    check(result_o == '0, "R1 mid-run reset result", result_o, 0);
    repeat (3) @(negedge clk);
    check(state_o == 3'b000, "R1 stays idle after reset", state_o, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule